// File: doc/BRIEF.md
# Strap-Protected Watchdog Reset Timer

This block is a watchdog that runs from its own slow oscillator, nominally 1 MHz, and is independent of the system clock. Software has to pulse a refresh strobe more often than a chosen timeout. If a timeout passes with no refresh, the block pulses a system reset request. The timeout is one of eight powers of two, picked by a 3-bit select. A counter in the watchdog clock domain measures it.

Two things protect the watchdog from stray software. First, a static strap input sets the safety level. At the higher level the watchdog is always on. Second, the enable bit and the period select change only through a timed unlock. A write that sets both the change bit and the enable bit opens a short window of system clocks. Only a write inside that window is taken. Any other write leaves the configuration alone.

The refresh strobe and the configuration cross into the watchdog domain through two-flop synchronizers. The reset request crosses back the same way.

The configuration state machine has two states:
- `CFG_LOCKED`: the normal state. The unlock write moves it to `CFG_OPEN`.
- `CFG_OPEN`: the window is open. An accepted write, or the end of the window, returns it to `CFG_LOCKED`.

The counter state machine also has two states:
- `CNT_IDLE`: the watchdog is disabled and the counter is held at zero.
- `CNT_RUN`: the counter is counting. It moves from `CNT_IDLE` to `CNT_RUN` when the synchronized enable rises, and back when the enable falls.

Top module: `wdt_fuse_guard`

## Requirements
- R1: The timeout is 2^(BASE_LOG2+sel) watchdog clock cycles. The code 3'b000 gives the shortest timeout and 3'b111 the longest, with BASE_LOG2 = 11 by default.
- R2: A one-cycle pulse on `kick` clears the watchdog counter. When `kick` pulses more often than the timeout, no reset request is raised.
- R3: Disabling the watchdog clears its counter. After it is enabled again, the full period runs before any request.
- R4: When the selected period runs out with no refresh, `rst_req` is high for exactly one system clock. It rises within a few synchronizer cycles of the timeout.
- R5: Chip reset (`rst_n` low) clears the counter and returns the select to 3'b000. After reset, `en_o` is 0 when `strap_hi` is 0 and 1 when `strap_hi` is 1.
- R6: A write (`cfg_wr`) with `cfg_chg`=1 and `cfg_on`=1 sets `chg_o` to 1 and leaves `en_o` and `sel_o` unchanged.
- R7: The first write on any of the 4 system clocks that follow the unlock write is applied. It loads `cfg_on` and `cfg_sel` and clears `chg_o`.
- R8: If no write arrives in those 4 clocks, `chg_o` returns to 0. A later write is then ignored.
- R9: A write that is not an unlock write and is not inside an open window leaves `en_o` and `sel_o` unchanged.
- R10: With `strap_hi`=1, `en_o` stays 1 even after a write with `cfg_on`=0. The period select can still be changed through the unlock sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_n | input | 1 | Chip reset, asynchronous, active low |
| clk_wd | input | 1 | Dedicated watchdog oscillator clock |
| strap_hi | input | 1 | Static safety-level strap (1 = always on); change it only while `rst_n` is low |
| kick | input | 1 | Refresh strobe, one system clock wide |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_chg | input | 1 | Change-enable bit of the write |
| cfg_on | input | 1 | Enable bit of the write |
| cfg_sel | input | 3 | Period select of the write |
| en_o | output | 1 | Current effective enable |
| sel_o | output | 3 | Current period select |
| chg_o | output | 1 | Unlock window open |
| rst_req | output | 1 | System reset request, one system clock |

## Verification
The checker tests the following on every cycle:
- the request pulse is never longer than one clock;
- the watchdog stays on at the high strap level;
- the configuration never moves while the window is closed;
- the window never lasts longer than its length;
- the counter is at zero after a disable or a refresh.

Some behaviour spans both clock domains, and only the bench scenarios can show it:
- the length of each timeout in system clocks for the different select codes;
- that a disable really discards the count built up before it;
- the exact window edge, where the fourth clock is accepted and the fifth is rejected;
- the post-reset timeout under the high strap.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    localparam int SEL_W = 3;

    typedef enum logic {
        CFG_LOCKED,
        CFG_OPEN
    } cfg_state_e;

    typedef enum logic {
        CNT_IDLE,
        CNT_RUN
    } cnt_state_e;

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

endmodule

// File: rtl/wdt_cfg_fsm.sv
module wdt_cfg_fsm
    import wdt_guard_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_hi,
    input  logic             cfg_wr,
    input  logic             cfg_chg,
    input  logic             cfg_on,
    input  logic [SEL_W-1:0] cfg_sel,
    output logic             en_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             chg_o
);

    localparam int WCW = $clog2(WIN + 1);

    cfg_state_e       state_q, state_d;
    logic [WCW-1:0]   win_q;
    logic             en_q;
    logic [SEL_W-1:0] sel_q;
    logic             unlock_wr;
    logic             win_last;

    assign unlock_wr = cfg_wr & cfg_chg & cfg_on;
    assign win_last  = (win_q == WCW'(WIN - 1));

    // Next-state logic: LOCKED -> OPEN on unlock, OPEN -> LOCKED on write or expiry
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_LOCKED: if (unlock_wr) state_d = CFG_OPEN;
            CFG_OPEN:   if (cfg_wr || win_last) state_d = CFG_LOCKED;
            default:    state_d = CFG_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_LOCKED;
        else        state_q <= state_d;
    end

    // Output and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= '0;
            win_q <= '0;
        end else begin
            unique case (state_q)
                CFG_LOCKED: win_q <= '0;
                CFG_OPEN: begin
                    win_q <= win_q + WCW'(1);
                    if (cfg_wr) begin
                        en_q  <= cfg_on;
                        sel_q <= cfg_sel;
                    end
                end
                default: win_q <= '0;
            endcase
        end
    end

    // The high strap level forces the watchdog on regardless of the stored bit
    assign en_o  = en_q | strap_hi;
    assign sel_o = sel_q;
    assign chg_o = (state_q == CFG_OPEN);

endmodule

// File: rtl/wdt_wd_counter.sv
module wdt_wd_counter
    import wdt_guard_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int CW        = BASE_LOG2 + 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             kick,
    output logic [CW-1:0]    cnt_q,
    output logic             fire_tog
);

    cnt_state_e    state_q, state_d;
    logic [CW-1:0] limit_m1;
    logic          hit;

    assign limit_m1 = (CW'(1) << (BASE_LOG2 + int'(sel))) - CW'(1);
    assign hit      = (cnt_q >= limit_m1);

    // Next state: IDLE -> RUN when enabled, RUN -> IDLE when disabled
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_IDLE: if (en)  state_d = CNT_RUN;
            CNT_RUN:  if (!en) state_d = CNT_IDLE;
            default:  state_d = CNT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_IDLE;
        else        state_q <= state_d;
    end

    // Counter and timeout event; each timeout flips fire_tog for the crossing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            fire_tog <= 1'b0;
        end else begin
            unique case (state_q)
                CNT_IDLE: cnt_q <= '0;
                CNT_RUN: begin
                    if (!en || kick || hit) cnt_q <= '0;
                    else                    cnt_q <= cnt_q + CW'(1);
                    if (en && !kick && hit) fire_tog <= ~fire_tog;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/wdt_fuse_guard.sv
module wdt_fuse_guard
    import wdt_guard_pkg::*;
#(
    parameter int BASE_LOG2 = 11,
    parameter int WIN       = 4
) (
    input  logic             clk_sys,
    input  logic             rst_n,
    input  logic             clk_wd,
    input  logic             strap_hi,
    input  logic             kick,
    input  logic             cfg_wr,
    input  logic             cfg_chg,
    input  logic             cfg_on,
    input  logic [SEL_W-1:0] cfg_sel,
    output logic             en_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             chg_o,
    output logic             rst_req
);

    localparam int CW   = BASE_LOG2 + 8;
    localparam int XW   = SEL_W + 2;

    logic          kick_tog;
    logic          rst_wd_n;
    logic [XW-1:0] xing_wd;
    logic          kick_s, kick_d, kick_wd;
    logic          en_wd;
    logic [SEL_W-1:0] sel_wd;
    logic [CW-1:0] wd_cnt;
    logic          fire_tog;
    logic          fire_s, fire_d;

    // System domain: configuration guard
    wdt_cfg_fsm #(.WIN(WIN)) u_cfg (
        .clk      (clk_sys),
        .rst_n    (rst_n),
        .strap_hi (strap_hi),
        .cfg_wr   (cfg_wr),
        .cfg_chg  (cfg_chg),
        .cfg_on   (cfg_on),
        .cfg_sel  (cfg_sel),
        .en_o     (en_o),
        .sel_o    (sel_o),
        .chg_o    (chg_o)
    );

    // Refresh strobe becomes a level toggle so that no pulse is lost in the crossing
    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) kick_tog <= 1'b0;
        else if (kick) kick_tog <= ~kick_tog;
    end

    // Watchdog domain reset: asynchronous assert, synchronous release
    wdt_sync #(.W(1)) u_rst_sync (
        .clk   (clk_wd),
        .rst_n (rst_n),
        .d     (1'b1),
        .q     (rst_wd_n)
    );

    wdt_sync #(.W(XW)) u_to_wd (
        .clk   (clk_wd),
        .rst_n (rst_wd_n),
        .d     ({kick_tog, en_o, sel_o}),
        .q     (xing_wd)
    );

    assign {kick_s, en_wd, sel_wd} = xing_wd;

    always_ff @(posedge clk_wd or negedge rst_wd_n) begin
        if (!rst_wd_n) kick_d <= 1'b0;
        else           kick_d <= kick_s;
    end

    assign kick_wd = kick_s ^ kick_d;

    wdt_wd_counter #(.BASE_LOG2(BASE_LOG2), .CW(CW)) u_cnt (
        .clk      (clk_wd),
        .rst_n    (rst_wd_n),
        .en       (en_wd),
        .sel      (sel_wd),
        .kick     (kick_wd),
        .cnt_q    (wd_cnt),
        .fire_tog (fire_tog)
    );

    // Back to the system domain: one registered pulse per timeout
    wdt_sync #(.W(1)) u_to_sys (
        .clk   (clk_sys),
        .rst_n (rst_n),
        .d     (fire_tog),
        .q     (fire_s)
    );

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            fire_d  <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            fire_d  <= fire_s;
            rst_req <= fire_s ^ fire_d;
        end
    end

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
    import wdt_guard_pkg::*;
#(
    parameter int WIN = 4,
    parameter int CW  = 19
) (
    input logic             clk_sys,
    input logic             rst_n,
    input logic             clk_wd,
    input logic             rst_wd_n,
    input logic             strap_hi,
    input logic             en_o,
    input logic [SEL_W-1:0] sel_o,
    input logic             chg_o,
    input logic             rst_req,
    input logic             en_wd,
    input logic             kick_wd,
    input logic [CW-1:0]    wd_cnt
);

    int open_run;

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n)     open_run <= 0;
        else if (chg_o) open_run <= open_run + 1;
        else            open_run <= 0;
    end

    assert_req_one_cycle_R4: assert property (@(posedge clk_sys) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_strap_keeps_on_R10: assert property (@(posedge clk_sys) disable iff (!rst_n)
        strap_hi |-> en_o);

    assert_locked_cfg_hold_R9: assert property (@(posedge clk_sys) disable iff (!rst_n)
        !chg_o |=> ($stable(en_o) && $stable(sel_o)));

    assert_window_length_R8: assert property (@(posedge clk_sys) disable iff (!rst_n)
        open_run <= WIN);

    assert_off_clears_cnt_R3: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
        !en_wd |=> (wd_cnt == '0));

    assert_kick_clears_cnt_R2: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
        kick_wd |=> (wd_cnt == '0));

endmodule

bind wdt_fuse_guard wdt_guard_chk #(.WIN(WIN), .CW(CW)) u_guard_chk (
    .clk_sys  (clk_sys),
    .rst_n    (rst_n),
    .clk_wd   (clk_wd),
    .rst_wd_n (rst_wd_n),
    .strap_hi (strap_hi),
    .en_o     (en_o),
    .sel_o    (sel_o),
    .chg_o    (chg_o),
    .rst_req  (rst_req),
    .en_wd    (en_wd),
    .kick_wd  (kick_wd),
    .wd_cnt   (wd_cnt)
);

// File: tb/wdt_fuse_guard_test.sv
module wdt_fuse_guard_test;

    localparam int BASE = 4;
    localparam int RATIO = 7;

    logic       clk_sys = 1'b0;
    logic       clk_wd  = 1'b0;
    logic       rst_n   = 1'b0;
    logic       strap_hi = 1'b0;
    logic       kick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_chg = 1'b0;
    logic       cfg_on = 1'b0;
    logic [2:0] cfg_sel = 3'd0;
    logic       en_o;
    logic [2:0] sel_o;
    logic       chg_o;
    logic       rst_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int req_count = 0;
    int last_req_cyc = 0;
    bit prev_req = 1'b0;

    // Behavioural model of the configuration guard
    bit       m_en_bit;
    bit [2:0] m_sel;
    bit       m_open;
    int       m_left;

    always #4 clk_sys = ~clk_sys;
    initial begin
        #3;
        forever #28 clk_wd = ~clk_wd;
    end

    wdt_fuse_guard #(.BASE_LOG2(BASE), .WIN(4)) uut (
        .clk_sys  (clk_sys),
        .rst_n    (rst_n),
        .clk_wd   (clk_wd),
        .strap_hi (strap_hi),
        .kick     (kick),
        .cfg_wr   (cfg_wr),
        .cfg_chg  (cfg_chg),
        .cfg_on   (cfg_on),
        .cfg_sel  (cfg_sel),
        .en_o     (en_o),
        .sel_o    (sel_o),
        .chg_o    (chg_o),
        .rst_req  (rst_req)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            m_en_bit = 1'b0;
            m_sel    = 3'd0;
            m_open   = 1'b0;
            m_left   = 0;
        end else if (m_open) begin
            if (cfg_wr) begin
                m_en_bit = cfg_on;
                m_sel    = cfg_sel;
                m_open   = 1'b0;
            end else begin
                m_left = m_left - 1;
                if (m_left == 0) m_open = 1'b0;
            end
        end else if (cfg_wr && cfg_chg && cfg_on) begin
            m_open = 1'b1;
            m_left = 4;
        end
    end

    // Per-clock comparison and request monitor
    always @(negedge clk_sys) begin
        cyc++;
        if (rst_n) begin
            chk(en_o == (m_en_bit | strap_hi), "R7 R10 model en_o", int'(en_o), int'(m_en_bit | strap_hi));
            chk(sel_o == m_sel, "R7 R9 model sel_o", int'(sel_o), int'(m_sel));
            chk(chg_o == m_open, "R6 R8 model chg_o", int'(chg_o), int'(m_open));
        end
        if (rst_req) begin
            req_count++;
            last_req_cyc = cyc;
        end
        if (prev_req && rst_req) chk(1'b0, "R4 pulse width", 2, 1);
        prev_req = rst_req;
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk_sys);
        errors++;
        $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    // All tasks start and end aligned to a falling system edge
    task automatic do_write(input bit chg, input bit on, input logic [2:0] sel);
        cfg_wr = 1'b1; cfg_chg = chg; cfg_on = on; cfg_sel = sel;
        @(negedge clk_sys);
        cfg_wr = 1'b0; cfg_chg = 1'b0; cfg_on = 1'b0;
    endtask

    task automatic do_kick();
        kick = 1'b1;
        @(negedge clk_sys);
        kick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_sys);
    endtask

    task automatic wait_req(input int n0, input int start, input int lo, input int hi, input string tag);
        while (req_count == n0 && cyc < start + hi + 10) @(posedge clk_sys);
        @(negedge clk_sys);
        if (req_count == n0) chk(1'b0, tag, -1, lo);
        else chk((last_req_cyc - start) >= lo && (last_req_cyc - start) <= hi, tag, last_req_cyc - start, lo);
    endtask

    initial begin
        int n0;
        int start;
        idle(5);
        @(posedge clk_sys); #2; rst_n = 1'b1;
        @(negedge clk_sys);

        // R5: low strap reset state
        chk(en_o == 1'b0, "R5 reset en_o", int'(en_o), 0);
        chk(sel_o == 3'd0, "R5 reset sel_o", int'(sel_o), 0);
        chk(chg_o == 1'b0, "R5 reset chg_o", int'(chg_o), 0);

        // R9: plain write with no unlock
        do_write(1'b0, 1'b1, 3'd5);
        idle(1);
        chk(en_o == 1'b0 && sel_o == 3'd0, "R9 write without unlock", int'(sel_o), 0);

        // R6 and R7: unlock then write two clocks later
        do_write(1'b1, 1'b1, 3'd0);
        chk(chg_o == 1'b1 && en_o == 1'b0, "R6 unlock opens window", int'(chg_o), 1);
        idle(1);
        do_write(1'b0, 1'b1, 3'd1);
        chk(en_o == 1'b1 && sel_o == 3'd1 && chg_o == 1'b0, "R7 write in window", int'(sel_o), 1);

        // R1 and R4: sel 1 gives 32 watchdog cycles
        n0 = req_count; start = cyc;
        do_kick();
        wait_req(n0, start, 32 * RATIO, 32 * RATIO + 45, "R1 R4 timeout sel1");

        // R2: steady refresh prevents any request
        n0 = req_count;
        for (int i = 0; i < 15; i++) begin
            do_kick();
            idle(100);
        end
        chk(req_count == n0, "R2 refresh holds off request", req_count - n0, 0);

        // R8: write on the fifth clock after unlock is refused
        do_write(1'b1, 1'b1, 3'd1);
        idle(4);
        chk(chg_o == 1'b0, "R8 window closed", int'(chg_o), 0);
        do_write(1'b0, 1'b1, 3'd3);
        chk(sel_o == 3'd1, "R8 late write ignored", int'(sel_o), 1);

        // R7 boundary: write on the fourth clock is taken
        do_write(1'b1, 1'b1, 3'd1);
        idle(3);
        do_write(1'b0, 1'b1, 3'd3);
        chk(sel_o == 3'd3, "R7 last window clock", int'(sel_o), 3);

        n0 = req_count; start = cyc;
        do_kick();
        wait_req(n0, start, 128 * RATIO, 128 * RATIO + 45, "R1 timeout sel3");

        // R3: disable discards the partial count
        do_kick();
        idle(600);
        do_write(1'b1, 1'b1, 3'd3);
        do_write(1'b0, 1'b0, 3'd3);
        chk(en_o == 1'b0, "R3 disabled", int'(en_o), 0);
        n0 = req_count;
        idle(2000);
        chk(req_count == n0, "R3 no request while off", req_count - n0, 0);
        n0 = req_count; start = cyc;
        do_write(1'b1, 1'b1, 3'd3);
        do_write(1'b0, 1'b1, 3'd3);
        wait_req(n0, start, 128 * RATIO, 128 * RATIO + 55, "R3 full period after enable");

        // R5 and R10: chip reset, then high strap
        do_kick();
        idle(300);
        @(posedge clk_sys); #2; rst_n = 1'b0; strap_hi = 1'b1;
        idle(10);
        @(posedge clk_sys); #2; rst_n = 1'b1;
        n0 = req_count; start = cyc;
        @(negedge clk_sys);
        chk(en_o == 1'b1 && sel_o == 3'd0 && chg_o == 1'b0, "R5 high strap reset state", int'(en_o), 1);
        wait_req(n0, start, 16 * RATIO, 16 * RATIO + 70, "R5 R10 timeout after reset");

        // R10: disable refused, period change accepted
        do_write(1'b1, 1'b1, 3'd0);
        do_write(1'b0, 1'b0, 3'd2);
        chk(en_o == 1'b1, "R10 disable ignored", int'(en_o), 1);
        chk(sel_o == 3'd2, "R10 period change", int'(sel_o), 2);
        n0 = req_count; start = cyc;
        do_kick();
        wait_req(n0, start, 64 * RATIO, 64 * RATIO + 45, "R1 R10 timeout sel2");

        // R9 at the high level
        do_write(1'b0, 1'b0, 3'd6);
        idle(1);
        chk(sel_o == 3'd2 && en_o == 1'b1, "R9 unguarded write high strap", int'(sel_o), 2);

        finish_run();
    end

endmodule